// File: doc/BRIEF.md
# Multi-cycle word-addressed processor datapath

This block is the register-transfer datapath of a small 32-bit load/store processor that spends several clock cycles on each instruction. It holds the program counter, the instruction register, a memory data register, two operand latches (A and B), an ALU result register and a 32-entry register file. One memory array serves both instruction fetch and data access. The block makes no decisions of its own. Every multiplexer select, write enable and ALU operation arrives on a control input from an external sequencer. The decoded opcode and function fields go back out to that sequencer.

Memory is addressed in words. The sequential next PC is therefore PC+1, and branch and jump targets are used as they are, with no shift. A host port writes and reads the memory array directly. The sequencer uses it to place a program and its data before execution and to read results back afterwards.

Top module: `mcdp_top`

## Requirements
- R1: After reset the PC is 0 and the instruction register is 0, so `opcode_o` and `funct_o` both read 0.
- R2: With `addr_sel`=0 the memory is addressed by the PC. A fetch step (`mem_rd`, `ir_wr`, `pc_wr`, A-select PC, B-select constant 1, ADD, `pc_src`=00) advances the PC by exactly one word.
- R3: The instruction register loads the memory output only on an edge where `ir_wr` is high, and otherwise holds its value. Its fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0], immediate [15:0] and jump index [25:0].
- R4: While `mem_rd` is low the memory output is zero, so an instruction-register load in that cycle yields 0.
- R5: With `addr_sel`=1 the memory is addressed by the ALU result register. A read is captured in the memory data register. A store writes operand B on the edge where `mem_wr` is high.
- R6: `dst_sel`=0 writes register rt and `dst_sel`=1 writes register rd. `wb_sel`=1 writes the memory data register and `wb_sel`=0 writes the ALU result register. A write happens only when `rf_wr` is high.
- R7: ALU codes: 0 AND, 1 OR, 2 ADD, 6 SUB, 7 signed set-less-than, 12 NOR, 3 shift B left by shamt, 4 logical shift B right by shamt, 5 shift B left by 16.
- R8: `opa_sel` picks the PC (0) or A (1). `opb_sel` picks B (00), the constant 1 (01) or the sign-extended 16-bit immediate (10).
- R9: With `pc_src`=01 and `pc_wr_cond` high, the PC loads the ALU result register only when the live ALU result is zero. The branch target is the incremented PC plus the sign-extended immediate.
- R10: With `pc_src`=10 and `pc_wr` high, the PC loads the zero-extended 26-bit jump index.
- R11: Register 0 reads as zero and ignores writes.
- R12: The host port writes a word into the shared memory array on a clock edge and reads any word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_wr | input | 1 | Unconditional PC update |
| pc_wr_cond | input | 1 | PC update if the ALU result is zero |
| addr_sel | input | 1 | Memory address: 0 PC, 1 ALU result register |
| mem_rd | input | 1 | Memory read enable |
| mem_wr | input | 1 | Memory write enable (writes B) |
| ir_wr | input | 1 | Instruction register load |
| dst_sel | input | 1 | Write register: 0 rt, 1 rd |
| wb_sel | input | 1 | Write data: 0 ALU result register, 1 memory data register |
| rf_wr | input | 1 | Register file write enable |
| opa_sel | input | 1 | ALU A source: 0 PC, 1 A |
| opb_sel | input | 2 | ALU B source: 00 B, 01 one, 10 immediate |
| pc_src | input | 2 | PC source: 00 live ALU, 01 ALU register, 10 jump |
| alu_ctl | input | 4 | ALU operation code |
| host_we | input | 1 | Host write to memory |
| host_addr | input | MEM_AW | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| opcode_o | output | 6 | Instruction opcode field |
| funct_o | output | 6 | Instruction function field |
| pc_o | output | 32 | Current PC |

## Verification
The assertions assume that the sequencer never raises `mem_wr` and `host_we` on the same edge. They also assume that the ALU code is one of the listed values whenever its result is used. The branch-hold property further assumes that a conditional PC write is paired with SUB. The bench drives each instruction as a fixed sequence of control steps (fetch, decode, then execute, memory and completion steps that match the instruction's class). All other controls are low in each step. Host writes are issued only between those sequences, so the memory never sees two writers on one edge.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;
  localparam int XLEN = 32;
  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [3:0] {
    ALU_AND = 4'd0,
    ALU_OR  = 4'd1,
    ALU_ADD = 4'd2,
    ALU_SLL = 4'd3,
    ALU_SRL = 4'd4,
    ALU_LUI = 4'd5,
    ALU_SUB = 4'd6,
    ALU_SLT = 4'd7,
    ALU_NOR = 4'd12
  } alu_op_e;

  typedef enum logic [1:0] {
    PCS_LIVE = 2'b00,
    PCS_HELD = 2'b01,
    PCS_JUMP = 2'b10
  } pc_src_e;

  function automatic word_t sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic word_t alu_calc(input logic [3:0] op, input word_t a,
                                     input word_t b, input logic [4:0] sh);
    word_t r;
    case (op)
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_SLT: r = ($signed(a) < $signed(b)) ? word_t'(1) : '0;
      ALU_NOR: r = ~(a | b);
      ALU_SLL: r = b << sh;
      ALU_SRL: r = b >> sh;
      ALU_LUI: r = b << 16;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
(
  input  logic [3:0] op,
  input  word_t      a,
  input  word_t      b,
  input  logic [4:0] sh,
  output word_t      y,
  output logic       zero
);
  always_comb begin
    y    = alu_calc(op, a, b, sh);
    zero = (y == '0);
  end
endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile
  import mcdp_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output word_t         rdata_a,
  output word_t         rdata_b
);
  word_t cells [NREGS];

  assign cells[0] = '0;

  for (genvar g = 1; g < NREGS; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cells[g] <= '0;
      else if (we && waddr == AW'(g))
        cells[g] <= wdata;
    end
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/mcdp_mem.sv
module mcdp_mem
  import mcdp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  word_t         wdata,
  output word_t         q,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  word_t         host_wdata,
  output word_t         host_q
);
  word_t arr [DEPTH];

  always_ff @(posedge clk) begin
    if (host_we)
      arr[host_addr] <= host_wdata;
    else if (wr_en)
      arr[addr] <= wdata;
  end

  assign q      = rd_en ? arr[addr] : '0;
  assign host_q = arr[host_addr];
endmodule

// File: rtl/mcdp_top.sv
module mcdp_top
  import mcdp_pkg::*;
#(
  parameter int MEM_DEPTH = 64,
  parameter int NUM_REGS  = 32,
  localparam int MEM_AW = $clog2(MEM_DEPTH),
  localparam int RF_AW  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_wr,
  input  logic              pc_wr_cond,
  input  logic              addr_sel,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              ir_wr,
  input  logic              dst_sel,
  input  logic              wb_sel,
  input  logic              rf_wr,
  input  logic              opa_sel,
  input  logic [1:0]        opb_sel,
  input  logic [1:0]        pc_src,
  input  logic [3:0]        alu_ctl,
  input  logic              host_we,
  input  logic [MEM_AW-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic [5:0]        opcode_o,
  output logic [5:0]        funct_o,
  output logic [31:0]       pc_o
);
  word_t pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;

  // instruction fields
  logic [4:0]  f_rs, f_rt, f_rd, f_shamt;
  logic [15:0] f_imm;
  logic [25:0] f_jidx;
  assign opcode_o = ir_q[31:26];
  assign f_rs     = ir_q[25:21];
  assign f_rt     = ir_q[20:16];
  assign f_rd     = ir_q[15:11];
  assign f_shamt  = ir_q[10:6];
  assign funct_o  = ir_q[5:0];
  assign f_imm    = ir_q[15:0];
  assign f_jidx   = ir_q[25:0];

  // operand selection
  word_t imm_ext, opnd_a, opnd_b, alu_y, jump_tgt, pc_next;
  logic  alu_zero, pc_load;
  assign imm_ext  = sext16(f_imm);
  assign opnd_a   = opa_sel ? a_q : pc_q;
  always_comb begin
    case (opb_sel)
      2'b00:   opnd_b = b_q;
      2'b01:   opnd_b = word_t'(1);
      2'b10:   opnd_b = imm_ext;
      default: opnd_b = '0;
    endcase
  end

  mcdp_alu u_alu (
    .op(alu_ctl), .a(opnd_a), .b(opnd_b), .sh(f_shamt), .y(alu_y), .zero(alu_zero)
  );

  // next PC
  assign jump_tgt = {{(XLEN-26){1'b0}}, f_jidx};
  always_comb begin
    case (pc_src)
      PCS_LIVE: pc_next = alu_y;
      PCS_HELD: pc_next = aluout_q;
      PCS_JUMP: pc_next = jump_tgt;
      default:  pc_next = alu_y;
    endcase
  end
  assign pc_load = pc_wr | (pc_wr_cond & alu_zero);

  // shared memory
  logic [MEM_AW-1:0] mem_addr;
  word_t             mem_q;
  assign mem_addr = addr_sel ? aluout_q[MEM_AW-1:0] : pc_q[MEM_AW-1:0];

  mcdp_mem #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk(clk), .rd_en(mem_rd), .wr_en(mem_wr), .addr(mem_addr), .wdata(b_q), .q(mem_q),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_q(host_rdata)
  );

  // register file
  logic [4:0] rf_waddr;
  word_t      rf_wdata, rf_ra, rf_rb;
  assign rf_waddr = dst_sel ? f_rd : f_rt;
  assign rf_wdata = wb_sel ? mdr_q : aluout_q;

  mcdp_regfile #(.NREGS(NUM_REGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_wr), .waddr(rf_waddr[RF_AW-1:0]), .wdata(rf_wdata),
    .raddr_a(f_rs[RF_AW-1:0]), .raddr_b(f_rt[RF_AW-1:0]), .rdata_a(rf_ra), .rdata_b(rf_rb)
  );

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      if (pc_load) pc_q <= pc_next;
      if (ir_wr)   ir_q <= mem_q;
      mdr_q    <= mem_q;
      a_q      <= rf_ra;
      b_q      <= rf_rb;
      aluout_q <= alu_y;
    end
  end

  assign pc_o = pc_q;

  // R2: fetch step adds exactly one word
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == 2'b00 && !opa_sel && opb_sel == 2'b01 && alu_ctl == 4'd2)
      |=> pc_q == $past(pc_q) + 32'd1);

  // R3: instruction register holds without a load
  p_ir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_wr |=> $stable(ir_q));

  // R4: a load with reads disabled captures zero
  p_ir_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_wr && !mem_rd) |=> ir_q == '0);

  // R9: no PC write request keeps the PC
  p_pc_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_wr && !pc_wr_cond) |=> $stable(pc_q));

  // R9: unequal compare operands do not take the branch
  p_br_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr_cond && !pc_wr && alu_ctl == 4'd6 && opnd_a != opnd_b) |=> $stable(pc_q));

  // R10: jump loads the index field
  p_jump_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == 2'b10) |=> pc_q == {6'b0, $past(ir_q[25:0])});
endmodule

// File: tb/mcdp_top_tb_top.sv
`timescale 1ns/1ps
module mcdp_top_tb_top;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, dst_sel, wb_sel, rf_wr, opa_sel;
  logic [1:0] opb_sel, pc_src;
  logic [3:0] alu_ctl;
  logic host_we;
  logic [AW-1:0] host_addr;
  logic [31:0] host_wdata, host_rdata, pc_o;
  logic [5:0] opcode_o, funct_o;

  always #2.5 clk = ~clk;

  mcdp_top dut_i (
    .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .dst_sel(dst_sel), .wb_sel(wb_sel),
    .rf_wr(rf_wr), .opa_sel(opa_sel), .opb_sel(opb_sel), .pc_src(pc_src), .alu_ctl(alu_ctl),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .opcode_o(opcode_o), .funct_o(funct_o), .pc_o(pc_o)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [31:0] m_rf [32];
  int m_pc;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    pc_wr = 0; pc_wr_cond = 0; addr_sel = 0; mem_rd = 0; mem_wr = 0; ir_wr = 0;
    dst_sel = 0; wb_sel = 0; rf_wr = 0; opa_sel = 0; opb_sel = 2'b00; pc_src = 2'b00;
    alu_ctl = 4'd0; host_we = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] ref_op(int k, logic [31:0] x, logic [31:0] y, int s);
    logic [31:0] d;
    case (k)
      0: return x & y;
      1: return x | y;
      2: return x + y;
      6: return x + ~y + 32'd1;
      7: begin
           if (x[31] != y[31]) return {31'd0, x[31]};
           d = x + ~y + 32'd1;
           return {31'd0, d[31]};
         end
      12: return ~x & ~y;
      3: return y << s;
      4: return y >> s;
      5: return {y[15:0], 16'd0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] sx(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic hwrite(input int a, input logic [31:0] d);
    host_we = 1; host_addr = AW'(a); host_wdata = d;
    tick();
  endtask

  task automatic peek(input int a, output logic [31:0] d);
    host_addr = AW'(a);
    #0.1;
    d = host_rdata;
  endtask

  task automatic fetch_raw(input logic [31:0] instr);
    hwrite(m_pc, instr);
    mem_rd = 1; ir_wr = 1; pc_wr = 1; opb_sel = 2'b01; alu_ctl = 4'd2; pc_src = 2'b00;
    tick();
    m_pc++;
    opb_sel = 2'b10; alu_ctl = 4'd2;
    tick();
  endtask

  task automatic fetch_decode(input logic [31:0] instr);
    if (m_pc >= 40) begin
      fetch_raw({6'd2, 26'd1});
      pc_wr = 1; pc_src = 2'b10;
      tick();
      m_pc = 1;
    end
    fetch_raw(instr);
  endtask

  task automatic run_r(input int rs, input int rt, input int rd, input int sh, input int fn, input int k);
    fetch_decode(enc_r(rs, rt, rd, sh, fn));
    opa_sel = 1; opb_sel = 2'b00; alu_ctl = 4'(k);
    tick();
    rf_wr = 1; dst_sel = 1; wb_sel = 0;
    tick();
    if (rd != 0) m_rf[rd] = ref_op(k, m_rf[rs], m_rf[rt], sh);
  endtask

  task automatic run_i(input int op, input int rs, input int rt, input logic [15:0] imm, input int k);
    fetch_decode(enc_i(op, rs, rt, imm));
    opa_sel = 1; opb_sel = 2'b10; alu_ctl = 4'(k);
    tick();
    rf_wr = 1; dst_sel = 0; wb_sel = 0;
    tick();
    if (rt != 0) m_rf[rt] = ref_op(k, m_rf[rs], sx(imm), 0);
  endtask

  task automatic run_lw(input int rt, input int base, input logic [15:0] imm, input logic [31:0] val);
    fetch_decode(enc_i(35, base, rt, imm));
    opa_sel = 1; opb_sel = 2'b10; alu_ctl = 4'd2;
    tick();
    mem_rd = 1; addr_sel = 1;
    tick();
    rf_wr = 1; dst_sel = 0; wb_sel = 1;
    tick();
    if (rt != 0) m_rf[rt] = val;
  endtask

  task automatic run_sw(input int rt, input int base, input logic [15:0] imm);
    fetch_decode(enc_i(43, base, rt, imm));
    opa_sel = 1; opb_sel = 2'b10; alu_ctl = 4'd2;
    tick();
    mem_wr = 1; addr_sel = 1;
    tick();
  endtask

  task automatic run_beq(input int rs, input int rt, input logic [15:0] imm);
    fetch_decode(enc_i(4, rs, rt, imm));
    opa_sel = 1; opb_sel = 2'b00; alu_ctl = 4'd6; pc_wr_cond = 1; pc_src = 2'b01;
    tick();
    if (m_rf[rs] == m_rf[rt]) m_pc = m_pc + int'($signed(sx(imm)));
  endtask

  task automatic run_j(input int tgt);
    fetch_decode({6'd2, 26'(tgt)});
    pc_wr = 1; pc_src = 2'b10;
    tick();
    m_pc = tgt;
  endtask

  task automatic chk_reg(input string req, input int r);
    logic [31:0] v;
    run_sw(r, 0, 16'd60);
    peek(60, v);
    chk(req, v, m_rf[r]);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 pc", pc_o, 32'd0);
    chk("R1 opcode", {26'd0, opcode_o}, 32'd0);
    chk("R1 funct", {26'd0, funct_o}, 32'd0);
  endtask

  task automatic t_host();
    logic [31:0] v;
    hwrite(48, 32'd7);
    hwrite(49, 32'hFFFF_FFFB);
    hwrite(50, 32'h8000_0001);
    peek(49, v);
    chk("R12 host readback", v, 32'hFFFF_FFFB);
  endtask

  task automatic t_fetch();
    fetch_decode(enc_r(0, 0, 0, 0, 42));
    chk("R2 pc step", pc_o, 32'(m_pc));
    chk("R3 funct field", {26'd0, funct_o}, 32'd42);
    fetch_decode(enc_i(8, 0, 0, 16'h0));
    chk("R2 pc step 2", pc_o, 32'(m_pc));
    chk("R3 opcode field", {26'd0, opcode_o}, 32'd8);
  endtask

  task automatic t_loads();
    run_lw(1, 0, 16'd48, 32'd7);
    run_lw(2, 0, 16'd49, 32'hFFFF_FFFB);
    run_lw(3, 1, 16'd43, 32'h8000_0001);   // 7 + 43 = 50
    chk_reg("R5 lw r1", 1);
    chk_reg("R5 lw r2", 2);
    chk_reg("R5 lw r3 base+offset", 3);
  endtask

  task automatic t_rtype();
    run_r(1, 2, 4, 0, 32, 2);  chk_reg("R7 add", 4);
    run_r(1, 2, 5, 0, 34, 6);  chk_reg("R7 sub", 5);
    run_r(1, 2, 6, 0, 36, 0);  chk_reg("R7 and", 6);
    run_r(1, 2, 7, 0, 37, 1);  chk_reg("R7 or", 7);
    run_r(1, 2, 8, 0, 39, 12); chk_reg("R7 nor", 8);
    run_r(2, 1, 9, 0, 42, 7);  chk_reg("R7 slt neg<pos", 9);
    run_r(1, 3, 10, 0, 42, 7); chk_reg("R7 slt pos<neg", 10);
    run_r(0, 1, 11, 3, 0, 3);  chk_reg("R7 sll", 11);
    run_r(0, 3, 12, 4, 2, 4);  chk_reg("R7 srl logical", 12);
    chk_reg("R6 rd dest only, r2 intact", 2);
  endtask

  task automatic t_imm();
    run_i(8, 2, 13, 16'hFFFD, 2);  chk_reg("R8 addi sign-ext", 13);
    run_i(10, 2, 14, 16'd10, 7);   chk_reg("R8 slti", 14);
    run_i(15, 0, 15, 16'h1234, 5); chk_reg("R7 lui", 15);
    chk_reg("R6 rt dest, rd-field reg r2 intact", 2);
  endtask

  task automatic t_r0();
    run_i(8, 1, 0, 16'd5, 2);
    chk_reg("R11 r0 after I write", 0);
    run_r(1, 1, 0, 0, 32, 2);
    chk_reg("R11 r0 after R write", 0);
  endtask

  task automatic t_memgate();
    logic [5:0] keep;
    hwrite(m_pc, enc_i(43, 1, 2, 16'h0));
    mem_rd = 1; ir_wr = 1;
    tick();
    chk("R3 load opcode", {26'd0, opcode_o}, 32'd43);
    keep = opcode_o;
    hwrite(m_pc, enc_i(10, 1, 2, 16'h0));
    mem_rd = 1; ir_wr = 0;
    tick();
    chk("R3 hold without ir_wr", {26'd0, opcode_o}, {26'd0, keep});
    mem_rd = 0; ir_wr = 1;
    tick();
    chk("R4 gated read opcode", {26'd0, opcode_o}, 32'd0);
    chk("R4 gated read funct", {26'd0, funct_o}, 32'd0);
    chk("R9 pc unchanged", pc_o, 32'(m_pc));
  endtask

  task automatic t_jump();
    run_j(20);
    chk("R10 jump target", pc_o, 32'd20);
  endtask

  task automatic t_branch();
    run_beq(1, 1, 16'd3);
    chk("R9 taken forward", pc_o, 32'(m_pc));
    chk("R9 taken value", pc_o, 32'd24);
    run_beq(1, 2, 16'd5);
    chk("R9 not taken", pc_o, 32'd25);
    run_beq(2, 2, 16'hFFFC);
    chk("R9 taken backward", pc_o, 32'd22);
  endtask

  initial begin
    idle();
    host_addr = '0; host_wdata = '0;
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
    m_pc = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_host();
    t_fetch();
    t_loads();
    t_rtype();
    t_imm();
    t_r0();
    t_memgate();
    t_jump();
    t_branch();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule